// File: doc/BRIEF.md
# Serial Peripheral Host Controller with Word Queues

This block is a memory-mapped controller that drives an external serial peripheral as the clock master. Software puts words into an eight-entry transmit queue through a data register. While the port is enabled, the block moves each word out and brings one word back. In normal operation the word goes through a shift engine using clock-idle-low, sample-on-rising-edge timing. In loopback it is copied internally. Each returned word lands in an eight-entry receive queue, and software pops it through the same data register.

The frame length can be set from 1 to 16 bits, and every word is cut to that length. Status and interrupt flags come from the queue fill levels. A four-bit mask selects which raw flags reach the single interrupt output. Host access is a word-indexed register bus: a word index, a write strobe, a read strobe, write data, and read data that is valid in the same cycle as the read strobe. A fixed eight-byte identity can be read from the top eight word indices.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status (index 3) reads 0x03, raw interrupt (index 6) reads 0x08, mask (index 5) reads 0 and `irq` is low.
- R2: Frame control (index 0) bits [3:0] hold frame length minus one. Every word written to the transmit queue, and every word stored in the receive queue, keeps only that many low bits.
- R3: With control (index 1) bit 1 (enable) and bit 0 (loopback) both set, each transmit word is copied to the receive queue and `cs_n` stays high.
- R4: Words move only while enable is set, the transmit queue is non-empty and the receive queue is not full. Order is preserved. A stalled move resumes after a data read frees a receive slot.
- R5: A data write (index 2) is dropped when the transmit queue holds 8 words. A data read with an empty receive queue returns 0.
- R6: Status bits: 0 = transmit empty, 1 = transmit not full, 2 = receive not empty, 3 = receive full, 4 = busy (transmit queue non-empty).
- R7: Raw interrupt bit 2 is set when the receive queue holds 4 or more words. Bit 3 is set when the transmit queue holds 4 or fewer. Bits 0 (overrun) and 1 (timeout) read 0, and a write to the clear register (index 8) leaves the raw value unchanged. Index 7 reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R8: In a serial frame `cs_n` is low for the whole frame and `sclk` is low when idle. `mosi` sends the word MSB first and changes only after falling edges. `miso` is sampled on rising edges, MSB first.
- R9: Each `sclk` half period lasts max(prescale with bit 0 cleared, 2) system clocks.
- R10: Prescale (index 4) keeps its low 8 bits. The DMA control register (index 9) reads 0 and writes to it have no effect.
- R11: Word indices 0x3F8 to 0x3FF read 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R12: Frame control reads back its low 16 bits, control its low 4 bits, and mask its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a data read pops the receive queue |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| irq | output | 1 | Combined masked interrupt |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Loopback is run with a single word, with a full queue of eight distinct words plus a ninth write that must be dropped, and with two extra words queued behind a full receive queue. Together these separate ordering faults, drop faults and faults in the stall-and-resume gating. The serial path uses a modelled peripheral whose return word differs from the sent word, at 12-bit and 4-bit frame lengths with two prescale values. This shows whether bit order, frame length and half-period length are each right. The interrupt flags are checked at fill levels of 0, 5 and 8 words, on both sides of each threshold.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // register word indices; host software depends on this layout
   localparam logic [3:0] RIX_FRAME  = 4'd0;
   localparam logic [3:0] RIX_CTRL   = 4'd1;
   localparam logic [3:0] RIX_DATA   = 4'd2;
   localparam logic [3:0] RIX_STAT   = 4'd3;
   localparam logic [3:0] RIX_PSC    = 4'd4;
   localparam logic [3:0] RIX_MASK   = 4'd5;
   localparam logic [3:0] RIX_RAW    = 4'd6;
   localparam logic [3:0] RIX_MASKED = 4'd7;
   localparam logic [3:0] RIX_CLEAR  = 4'd8;
   localparam logic [3:0] RIX_DMA    = 4'd9;

   typedef struct packed {
      logic out_off;
      logic peer_mode;
      logic enable;
      logic loopback;
   } ctrl_t;

   typedef struct packed {
      logic busy;
      logic rx_full;
      logic rx_avail;
      logic tx_room;
      logic tx_empty;
   } stat_t;

   typedef struct packed {
      logic tx_low;
      logic rx_high;
      logic timeout;
      logic overrun;
   } irq_t;

   function automatic logic [7:0] ident_byte(input logic [2:0] k);
      logic [7:0] b;
      case (k)
         3'd0: b = 8'h22;
         3'd1: b = 8'h10;
         3'd2: b = 8'h04;
         3'd3: b = 8'h00;
         3'd4: b = 8'h0D;
         3'd5: b = 8'hF0;
         3'd6: b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic [W-1:0]                 data_i,
   input  logic                         pop_i,
   output logic [W-1:0]                 head_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         empty_o,
   output logic                         full_o
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_word_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty_o = (cnt == '0);
   assign full_o  = (cnt == CW'(DEPTH));
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign head_o  = mem[rptr];
   assign count_o = cnt;

   if (POW2) begin : g_wrap_free
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= data_i;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i)
      else $error("push into full queue"); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> !pop_i)
      else $error("pop from empty queue"); // R4

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int W     = 16,
   parameter int SW    = 4,
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [W-1:0]     word_i,
   input  logic [SW-1:0]    last_bit_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [W-1:0]     rx_o,
   output logic             sclk_o,
   output logic             cs_n_o,
   output logic             mosi_o,
   input  logic             miso_i
);
   if (PSC_W < 2) begin : g_bad_psc
      $error("spi_shift_engine: PSC_W must be at least 2");
   end

   logic [PSC_W-1:0] half, cnt;
   logic [SW-1:0]    bits_left, last_bit;
   logic [W-1:0]     tx_sh, rx_sh;
   logic             busy, done, sclk, cs_n;
   wire              unused_psc_lsb = psc_i[0];

   always_comb begin
      half = {psc_i[PSC_W-1:1], 1'b0};
      if (half < PSC_W'(2)) half = PSC_W'(2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         sclk      <= 1'b0;
         cs_n      <= 1'b1;
         cnt       <= '0;
         bits_left <= '0;
         last_bit  <= '0;
         tx_sh     <= '0;
         rx_sh     <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start_i) begin
               busy      <= 1'b1;
               cs_n      <= 1'b0;
               sclk      <= 1'b0;
               cnt       <= '0;
               bits_left <= last_bit_i;
               last_bit  <= last_bit_i;
               tx_sh     <= word_i;
               rx_sh     <= '0;
            end
         end else if (cnt == half - 1'b1) begin
            cnt <= '0;
            if (!sclk) begin
               sclk  <= 1'b1;
               rx_sh <= {rx_sh[W-2:0], miso_i};
            end else begin
               sclk <= 1'b0;
               if (bits_left == '0) begin
                  busy <= 1'b0;
                  cs_n <= 1'b1;
                  done <= 1'b1;
               end else begin
                  bits_left <= bits_left - 1'b1;
                  tx_sh     <= {tx_sh[W-2:0], 1'b0};
               end
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign busy_o = busy;
   assign done_o = done;
   assign rx_o   = rx_sh;
   assign sclk_o = sclk;
   assign cs_n_o = cs_n;
   assign mosi_o = tx_sh[last_bit];

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o)
      else $error("clock active outside a frame"); // R8
   AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o))
      else $error("data out moved while clock high"); // R8
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> $past(start_i))
      else $error("frame began without a start"); // R8

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int PSC_W      = 8,
   parameter int ADDR_W     = 10,
   parameter int BUS_W      = 32,
   parameter int RX_THRESH  = 4,
   parameter int TX_THRESH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso
);
   localparam int SW      = $clog2(DATA_W);
   localparam int CW      = $clog2(FIFO_DEPTH + 1);
   localparam int FRAME_W = 16;
   localparam logic [ADDR_W-1:0] ID_BASE = ADDR_W'((1 << ADDR_W) - 8);

   if (BUS_W < FRAME_W) begin : g_bad_bus
      $error("spi_host_ctrl: BUS_W must be at least 16");
   end
   if (DATA_W < 4 || DATA_W > BUS_W || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("spi_host_ctrl: DATA_W must be a power of two from 4 to BUS_W");
   end
   if (RX_THRESH > FIFO_DEPTH || TX_THRESH > FIFO_DEPTH) begin : g_bad_thresh
      $error("spi_host_ctrl: thresholds exceed queue depth");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("spi_host_ctrl: ADDR_W too small for the map");
   end

   // configuration state
   logic [FRAME_W-1:0] frame_q;
   ctrl_t              ctrl_q;
   logic [PSC_W-1:0]   psc_q;
   logic [3:0]         mask_q;

   // decode
   logic reg_hit;
   logic wr_frame, wr_ctrl, wr_data, wr_psc, wr_mask, rd_data;
   assign reg_hit  = (bus_addr[ADDR_W-1:4] == '0);
   assign wr_frame = bus_wr && reg_hit && bus_addr[3:0] == RIX_FRAME;
   assign wr_ctrl  = bus_wr && reg_hit && bus_addr[3:0] == RIX_CTRL;
   assign wr_data  = bus_wr && reg_hit && bus_addr[3:0] == RIX_DATA;
   assign wr_psc   = bus_wr && reg_hit && bus_addr[3:0] == RIX_PSC;
   assign wr_mask  = bus_wr && reg_hit && bus_addr[3:0] == RIX_MASK;
   assign rd_data  = bus_rd && reg_hit && bus_addr[3:0] == RIX_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         ctrl_q  <= '0;
         psc_q   <= '0;
         mask_q  <= '0;
      end else begin
         if (wr_frame) frame_q <= bus_wdata[FRAME_W-1:0];
         if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[3:0]);
         if (wr_psc)   psc_q   <= bus_wdata[PSC_W-1:0];
         if (wr_mask)  mask_q  <= bus_wdata[3:0];
      end
   end

   // word length mask
   logic [SW-1:0]   last_bit;
   logic [DATA_W:0] mask_wide;
   logic [DATA_W-1:0] word_mask;
   assign last_bit  = frame_q[SW-1:0];
   assign mask_wide = ({{DATA_W{1'b0}}, 1'b1} << (int'(last_bit) + 1)) - 1'b1;
   assign word_mask = mask_wide[DATA_W-1:0];

   // queues
   logic [DATA_W-1:0] tx_head, rx_head, rx_in, eng_rx;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic              tx_push, tx_pop, rx_push, rx_pop;
   logic              lb_move, eng_start, eng_busy, eng_done, can_move;

   assign tx_push = wr_data && !tx_full;
   assign rx_pop  = rd_data && !rx_empty;

   spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push_i(tx_push), .data_i(bus_wdata[DATA_W-1:0] & word_mask),
      .pop_i(tx_pop), .head_o(tx_head), .count_o(tx_cnt),
      .empty_o(tx_empty), .full_o(tx_full));

   spi_word_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push_i(rx_push), .data_i(rx_in),
      .pop_i(rx_pop), .head_o(rx_head), .count_o(rx_cnt),
      .empty_o(rx_empty), .full_o(rx_full));

   // transfer sequencing
   assign can_move  = ctrl_q.enable && !tx_empty && !rx_full && !eng_busy && !eng_done;
   assign lb_move   = can_move && ctrl_q.loopback;
   assign eng_start = can_move && !ctrl_q.loopback;
   assign tx_pop    = lb_move || eng_done;
   assign rx_push   = lb_move || eng_done;
   assign rx_in     = (lb_move ? tx_head : eng_rx) & word_mask;

   spi_shift_engine #(.W(DATA_W), .SW(SW), .PSC_W(PSC_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start_i(eng_start), .word_i(tx_head), .last_bit_i(last_bit),
      .psc_i(psc_q), .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx),
      .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso));

   // status and interrupts
   stat_t stat;
   irq_t  raw;
   logic [3:0] masked;
   assign stat.tx_empty = tx_empty;
   assign stat.tx_room  = !tx_full;
   assign stat.rx_avail = !rx_empty;
   assign stat.rx_full  = rx_full;
   assign stat.busy     = !tx_empty;
   assign raw.overrun   = 1'b0;
   assign raw.timeout   = 1'b0;
   assign raw.rx_high   = (rx_cnt >= CW'(RX_THRESH));
   assign raw.tx_low    = (tx_cnt <= CW'(TX_THRESH));
   assign masked        = raw & mask_q;
   assign irq           = |masked;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr >= ID_BASE) begin
         bus_rdata[7:0] = ident_byte(bus_addr[2:0]);
      end else if (reg_hit) begin
         case (bus_addr[3:0])
            RIX_FRAME:  bus_rdata[FRAME_W-1:0] = frame_q;
            RIX_CTRL:   bus_rdata[3:0] = ctrl_q;
            RIX_DATA:   if (!rx_empty) bus_rdata[DATA_W-1:0] = rx_head;
            RIX_STAT:   bus_rdata[4:0] = stat;
            RIX_PSC:    bus_rdata[PSC_W-1:0] = psc_q;
            RIX_MASK:   bus_rdata[3:0] = mask_q;
            RIX_RAW:    bus_rdata[3:0] = raw;
            RIX_MASKED: bus_rdata[3:0] = masked;
            default:    bus_rdata = '0;
         endcase
      end
   end

   wire unused_top = ^{bus_wdata[BUS_W-1:FRAME_W], ctrl_q.peer_mode, ctrl_q.out_off};

   AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full)
      else $error("receive push without room"); // R4
   AST_LOOP_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.loopback && !eng_busy) |-> cs_n)
      else $error("frame select active in loopback"); // R3
   AST_FRAME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(ctrl_q.enable))
      else $error("frame started while disabled"); // R4
   AST_MOVE_TAKES_TX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !tx_empty)
      else $error("receive push with nothing sent"); // R4

endmodule

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, sclk, cs_n, mosi;
   logic        miso = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   spi_host_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

   // peripheral model, evaluated away from the active edge
   logic [15:0] sl_word = '0, sl_sh = '0, mosi_cap = '0;
   int          sl_last = 0;
   logic        prev_cs = 1'b1, prev_sclk = 1'b0;

   always @(negedge clk) begin
      if (prev_cs && !cs_n) begin
         sl_sh    = sl_word;
         miso     = sl_word[sl_last];
         mosi_cap = '0;
      end else if (!cs_n && prev_sclk && !sclk) begin
         sl_sh = sl_sh << 1;
         miso  = sl_sh[sl_last];
      end
      if (!cs_n && !prev_sclk && sclk) mosi_cap = {mosi_cap[14:0], mosi};
      prev_cs   = cs_n;
      prev_sclk = sclk;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_reg(input string req, input logic [9:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      expect_reg("R1 status", 10'd3, 32'h03);
      expect_reg("R1 raw", 10'd6, 32'h08);
      expect_reg("R1 mask", 10'd5, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);
      expect_reg("R5 empty read", 10'd2, 32'h0);
   endtask

   task automatic t_regs();
      bus_write(10'd0, 32'hFFFF_1237);
      expect_reg("R12 frame readback", 10'd0, 32'h1237);
      bus_write(10'd1, 32'hFFFF_FFF4);
      expect_reg("R12 control readback", 10'd1, 32'h4);
      bus_write(10'd5, 32'hF3);
      expect_reg("R12 mask readback", 10'd5, 32'h3);
      bus_write(10'd5, 32'h0);
      bus_write(10'd4, 32'h1FF);
      expect_reg("R10 prescale low bits", 10'd4, 32'hFF);
      bus_write(10'd9, 32'hFFFF_FFFF);
      expect_reg("R10 dma reads zero", 10'd9, 32'h0);
      expect_reg("R10 dma write no effect on status", 10'd3, 32'h03);
      begin
         logic [7:0] ident [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
         for (int k = 0; k < 8; k++)
            expect_reg("R11 identity", 10'h3F8 + 10'(k), {24'd0, ident[k]});
      end
      bus_write(10'd1, 32'h0);
   endtask

   task automatic t_loopback();
      logic [31:0] v;
      bus_write(10'd0, 32'h7);
      bus_write(10'd1, 32'h3);
      bus_write(10'd2, 32'h1A5);
      idle(2);
      check("R3 cs_n stays high", {31'd0, cs_n}, 32'h1);
      expect_reg("R6 status one rx word", 10'd3, 32'h07);
      bus_read(10'd2, v);
      check("R2 R3 loopback word truncated", v, 32'hA5);
      bus_write(10'd0, 32'h3);
      bus_write(10'd2, 32'hFF);
      idle(2);
      bus_read(10'd2, v);
      check("R2 four-bit frame", v, 32'hF);
      bus_write(10'd0, 32'h7);
   endtask

   task automatic t_stall();
      logic [31:0] v;
      bus_write(10'd1, 32'h0);
      for (int k = 0; k < 9; k++) bus_write(10'd2, 32'h10 + k);
      idle(2);
      expect_reg("R6 tx full status", 10'd3, 32'h10);
      expect_reg("R7 raw with tx full", 10'd6, 32'h0);
      expect_reg("R4 disabled no move", 10'd3, 32'h10);
      bus_write(10'd1, 32'h3);
      idle(12);
      expect_reg("R6 rx full status", 10'd3, 32'h0F);
      expect_reg("R7 raw with rx full", 10'd6, 32'h0C);
      bus_write(10'd2, 32'h77);
      bus_write(10'd2, 32'h66);
      idle(3);
      expect_reg("R4 stalled behind full rx", 10'd3, 32'h1E);
      for (int k = 0; k < 8; k++) begin
         bus_read(10'd2, v);
         check("R4 R5 order and drop", v, 32'h10 + k);
         idle(1);
      end
      bus_read(10'd2, v);
      check("R4 resumed word", v, 32'h77);
      bus_read(10'd2, v);
      check("R4 resumed word", v, 32'h66);
      bus_read(10'd2, v);
      check("R5 empty read zero", v, 32'h0);
      expect_reg("R6 all empty", 10'd3, 32'h03);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      bus_write(10'd1, 32'h0);
      bus_write(10'd5, 32'hC);
      idle(1);
      check("R7 irq tx low", {31'd0, irq}, 32'h1);
      expect_reg("R7 masked tx low", 10'd7, 32'h8);
      for (int k = 0; k < 5; k++) bus_write(10'd2, 32'h40 + k);
      idle(1);
      expect_reg("R7 raw at five tx", 10'd6, 32'h0);
      check("R7 irq low at five tx", {31'd0, irq}, 32'h0);
      bus_write(10'd8, 32'hF);
      expect_reg("R7 clear leaves raw", 10'd6, 32'h0);
      bus_write(10'd1, 32'h3);
      idle(8);
      expect_reg("R7 raw at five rx", 10'd6, 32'h0C);
      bus_write(10'd5, 32'h4);
      expect_reg("R7 masked rx high", 10'd7, 32'h4);
      check("R7 irq rx high", {31'd0, irq}, 32'h1);
      bus_write(10'd5, 32'h0);
      idle(1);
      check("R7 irq masked off", {31'd0, irq}, 32'h0);
      for (int k = 0; k < 5; k++) begin
         bus_read(10'd2, v);
         check("R4 drain order", v, 32'h40 + k);
      end
   endtask

   task automatic serial_frame(input logic [31:0] frame, input logic [31:0] psc,
                               input logic [15:0] send, input logic [15:0] reply,
                               input int last, input int half);
      logic [31:0] v;
      int n;
      bus_write(10'd1, 32'h0);
      bus_write(10'd0, frame);
      bus_write(10'd4, psc);
      sl_word = reply;
      sl_last = last;
      bus_write(10'd1, 32'h2);
      bus_write(10'd2, {16'd0, send});
      @(posedge sclk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (sclk);
      check("R9 clock high length", n, half + 1);
      v = 0;
      for (int k = 0; k < 4000 && v[2] == 1'b0; k++) begin
         bus_read(10'd3, v);
      end
      check("R8 cs_n released", {31'd0, cs_n}, 32'h1);
      bus_read(10'd2, v);
      check("R8 miso word", v, 32'(reply & 16'((1 << (last + 1)) - 1)));
      check("R8 mosi word", 32'(mosi_cap & 16'((1 << (last + 1)) - 1)),
            32'(send & 16'((1 << (last + 1)) - 1)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_regs();
      t_loopback();
      t_stall();
      t_irq();
      serial_frame(32'hB, 32'h3, 16'hFABC, 16'h05A3, 11, 2);
      serial_frame(32'h3, 32'h7, 16'h0006, 16'h0009, 3, 6);
      finish_run();
   end

endmodule